// File: doc/BRIEF.md
# Translation Fault Recorder

This block keeps the two registers that software reads after a failed address translation: a status word describing the most recent fault and an address word naming the page that caused it. The table walker reports a fault as a one-cycle strobe. The strobe carries the walk level, the fault kind, the access index and the virtual address. The block folds these into the status word. If an earlier fault was never read, the block marks the status as overwritten. It stores the page-aligned address. It then either signals a trap to the core or, when no-fault operation is on or traps are disabled, signals that the access may proceed with full permissions.

A separate strobe reports misaligned accesses. That strobe only records the full byte address and raises an alignment trap. Software reaches both registers through a single-cycle port. A select bit chooses the register. Reading the status word consumes it, so the word returns to zero on the following clock edge.

Top module: `mmu_fault_regs`

## Requirements
- R1: After reset the status and address registers read as zero and all four event outputs (`trap_inst`, `trap_data`, `trap_align`, `grant_all`) are low.
- R2: A fault loads the status word as follows:
  - bits [9:8] hold the walk level;
  - bits [7:5] hold the access index;
  - bits [4:2] hold the fault kind;
  - bit 1 is set as the address-valid flag;
  - all bits above 9 read as zero.
- R3: When a fault arrives while the status word is nonzero and not being read in that cycle, the previous contents are discarded and replaced by the overwrite marker in bit 0, before the new fields are merged. When the status word is zero or is being read in that cycle, bit 0 stays clear.
- R4: A fault loads the address register with the virtual address with its low `PAGE_SHIFT` (default 12) bits cleared.
- R5: When `nofault_mode` is high or `traps_on` is low at the time of a fault, the cycle after the fault `grant_all` pulses and neither fault trap is raised.
- R6: Otherwise the cycle after the fault raises `trap_inst` if `flt_ifetch` is high and `trap_data` if it is low, each as a one-cycle pulse.
- R7: A misalignment strobe loads the full unmodified address into the address register, leaves the status word unchanged and pulses `trap_align` the next cycle. If a fault arrives in the same cycle, the fault's address wins.
- R8: `reg_sel` = 0 selects status and `reg_sel` = 1 selects address.
  - `reg_rdata` shows the selected register in the same cycle.
  - A read of the status word clears it at the next edge.
  - A read of the address word changes nothing.
- R9: A write loads the selected register. Status keeps only bits [9:0].
  - A fault in the same cycle overrides a status write.
  - A fault or misalignment overrides an address write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 1 | One-cycle translation fault strobe |
| flt_ifetch | input | 1 | Faulting access was an instruction fetch |
| flt_level | input | 2 | Walk level at which the fault occurred |
| flt_kind | input | 3 | Fault kind code from the walker |
| flt_acc_idx | input | 3 | Access index (read/write, fetch, privilege) |
| flt_vaddr | input | ADDR_W | Faulting virtual address |
| nofault_mode | input | 1 | No-fault control bit |
| traps_on | input | 1 | Trap enable state of the core |
| ua_valid | input | 1 | Misaligned access strobe |
| ua_addr | input | ADDR_W | Misaligned byte address |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status, 1 = address |
| reg_wdata | input | ADDR_W | Write data |
| reg_rdata | output | ADDR_W | Read data of selected register |
| trap_inst | output | 1 | Instruction access trap pulse |
| trap_data | output | 1 | Data access trap pulse |
| trap_align | output | 1 | Alignment trap pulse |
| grant_all | output | 1 | Suppressed fault, grant full permissions |

## Verification
The assertions assume that every strobe lasts exactly one cycle. They also assume that `reg_rd` and `reg_wr` are not raised together for the status word, because otherwise the clear-on-read and write checks would overlap. The stimulus drives every event for a single clock and then returns all strobes to low. It keeps read and write in separate cycles, except for the deliberate collisions of a fault with a write, a fault with a read, and a fault with a misalignment. Expected status values are built in the bench from the field layout of R2 and the overwrite rule of R3.

// File: rtl/mmu_fsr_pkg.sv
package mmu_fsr_pkg;
  localparam int STAT_W   = 10;
  localparam int OW_BIT   = 0;
  localparam int AV_BIT   = 1;

  // Field layout: level [9:8], access index [7:5], kind [4:2], valid [1], overwrite [0]
  function automatic logic [STAT_W-1:0] fsr_fields(input logic [1:0] lvl,
                                                   input logic [2:0] acc,
                                                   input logic [2:0] kind);
    return {lvl, acc, kind, 1'b1, 1'b0};
  endfunction

  typedef struct packed {
    logic inst;
    logic data;
    logic align;
    logic grant;
  } trap_vec_t;
endpackage

// File: rtl/fsr_status_next.sv
module fsr_status_next
  import mmu_fsr_pkg::*;
(
  input  logic [STAT_W-1:0] cur,
  input  logic              fault,
  input  logic [1:0]        lvl,
  input  logic [2:0]        acc,
  input  logic [2:0]        kind,
  input  logic              rd_clr,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] nxt
);
  logic [STAT_W-1:0] base;
  logic [STAT_W-1:0] ow_mark;

  always_comb begin
    base    = rd_clr ? '0 : cur;
    ow_mark = '0;
    if (base != '0) ow_mark[OW_BIT] = 1'b1;
    if (fault)      nxt = ow_mark | fsr_fields(lvl, acc, kind);
    else if (wr_en) nxt = wdata;
    else            nxt = base;
  end
endmodule

// File: rtl/fsr_addr_next.sv
module fsr_addr_next #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic              fault,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              ua,
  input  logic [ADDR_W-1:0] ua_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = {ADDR_W{1'b1}} << PAGE_SHIFT;

  always_comb begin
    if (fault)      nxt = vaddr & PAGE_MASK;
    else if (ua)    nxt = ua_addr;
    else if (wr_en) nxt = wdata;
    else            nxt = cur;
  end
endmodule

// File: rtl/fsr_trap_decide.sv
module fsr_trap_decide
  import mmu_fsr_pkg::*;
(
  input  logic      fault,
  input  logic      ifetch,
  input  logic      nofault_mode,
  input  logic      traps_on,
  input  logic      ua,
  output trap_vec_t nxt
);
  logic quiet;

  always_comb begin
    quiet     = nofault_mode | ~traps_on;
    nxt.grant = fault & quiet;
    nxt.inst  = fault & ~quiet & ifetch;
    nxt.data  = fault & ~quiet & ~ifetch;
    nxt.align = ua;
  end
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
  import mmu_fsr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  input  logic              flt_ifetch,
  input  logic [1:0]        flt_level,
  input  logic [2:0]        flt_kind,
  input  logic [2:0]        flt_acc_idx,
  input  logic [ADDR_W-1:0] flt_vaddr,
  input  logic              nofault_mode,
  input  logic              traps_on,
  input  logic              ua_valid,
  input  logic [ADDR_W-1:0] ua_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              trap_inst,
  output logic              trap_data,
  output logic              trap_align,
  output logic              grant_all
);
  localparam logic SEL_STAT = 1'b0;
  localparam logic SEL_ADDR = 1'b1;

  logic [STAT_W-1:0] stat_q, stat_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  trap_vec_t         trap_q, trap_d;
  logic              stat_rd, stat_wr, addr_wr;
  logic              stat_en, addr_en;

  assign stat_rd = reg_rd & (reg_sel == SEL_STAT);
  assign stat_wr = reg_wr & (reg_sel == SEL_STAT);
  assign addr_wr = reg_wr & (reg_sel == SEL_ADDR);
  assign stat_en = flt_valid | stat_rd | stat_wr;
  assign addr_en = flt_valid | ua_valid | addr_wr;

  fsr_status_next u_stat (
    .cur   (stat_q),
    .fault (flt_valid),
    .lvl   (flt_level),
    .acc   (flt_acc_idx),
    .kind  (flt_kind),
    .rd_clr(stat_rd),
    .wr_en (stat_wr),
    .wdata (reg_wdata[STAT_W-1:0]),
    .nxt   (stat_d)
  );

  fsr_addr_next #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_addr (
    .cur    (addr_q),
    .fault  (flt_valid),
    .vaddr  (flt_vaddr),
    .ua     (ua_valid),
    .ua_addr(ua_addr),
    .wr_en  (addr_wr),
    .wdata  (reg_wdata),
    .nxt    (addr_d)
  );

  fsr_trap_decide u_trap (
    .fault       (flt_valid),
    .ifetch      (flt_ifetch),
    .nofault_mode(nofault_mode),
    .traps_on    (traps_on),
    .ua          (ua_valid),
    .nxt         (trap_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= '0;
    else        trap_q <= trap_d;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_ADDR) reg_rdata = addr_q;
    else                     reg_rdata[STAT_W-1:0] = stat_q;
  end

  assign trap_inst  = trap_q.inst;
  assign trap_data  = trap_q.data;
  assign trap_align = trap_q.align;
  assign grant_all  = trap_q.grant;
endmodule

// File: rtl/mmu_fault_regs_chk.sv
module mmu_fault_regs_chk #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flt_valid,
  input logic              flt_ifetch,
  input logic [ADDR_W-1:0] flt_vaddr,
  input logic              nofault_mode,
  input logic              traps_on,
  input logic              ua_valid,
  input logic [ADDR_W-1:0] ua_addr,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [9:0]        stat_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic              trap_inst,
  input logic              trap_data,
  input logic              grant_all,
  input logic              trap_align
);
  // R6
  fault_trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_inst, trap_data, grant_all}));

  // R5
  quiet_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && (nofault_mode || !traps_on) |=> grant_all && !trap_inst && !trap_data);

  // R6
  ifetch_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !nofault_mode && traps_on && flt_ifetch |=> trap_inst);

  // R6
  data_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !nofault_mode && traps_on && !flt_ifetch |=> trap_data);

  // R7
  align_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ua_valid |=> trap_align);

  // R7
  align_keeps_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ua_valid && !flt_valid && !reg_wr && !reg_rd |=> $stable(stat_q));

  // R4
  page_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> addr_q == (($past(flt_vaddr) >> PAGE_SHIFT) << PAGE_SHIFT));

  // R2
  valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> stat_q[1]);

  // R3
  overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && stat_q != 10'd0 && !(reg_rd && !reg_sel) |=> stat_q[0]);

  // R3
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && (stat_q == 10'd0 || (reg_rd && !reg_sel)) |=> !stat_q[0]);

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !reg_sel && !flt_valid && !reg_wr |=> stat_q == 10'd0);

  // R7
  align_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ua_valid && !flt_valid |=> addr_q == $past(ua_addr));
endmodule

bind mmu_fault_regs mmu_fault_regs_chk #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flt_valid   (flt_valid),
  .flt_ifetch  (flt_ifetch),
  .flt_vaddr   (flt_vaddr),
  .nofault_mode(nofault_mode),
  .traps_on    (traps_on),
  .ua_valid    (ua_valid),
  .ua_addr     (ua_addr),
  .reg_rd      (reg_rd),
  .reg_wr      (reg_wr),
  .reg_sel     (reg_sel),
  .stat_q      (stat_q),
  .addr_q      (addr_q),
  .trap_inst   (trap_inst),
  .trap_data   (trap_data),
  .grant_all   (grant_all),
  .trap_align  (trap_align)
);

// File: tb/mmu_fault_regs_test.sv
module mmu_fault_regs_test;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flt_valid, flt_ifetch, nofault_mode, traps_on, ua_valid;
  logic [1:0]    flt_level;
  logic [2:0]    flt_kind, flt_acc_idx;
  logic [AW-1:0] flt_vaddr, ua_addr, reg_wdata, reg_rdata;
  logic          reg_rd, reg_wr, reg_sel;
  logic          trap_inst, trap_data, trap_align, grant_all;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] ev;
    string      req;
  } exp_t;
  exp_t q[$];

  logic [9:0]    m_stat;
  logic [AW-1:0] m_addr;

  always #4 clk = ~clk;

  mmu_fault_regs uut (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_ifetch(flt_ifetch),
    .flt_level(flt_level), .flt_kind(flt_kind), .flt_acc_idx(flt_acc_idx),
    .flt_vaddr(flt_vaddr), .nofault_mode(nofault_mode), .traps_on(traps_on),
    .ua_valid(ua_valid), .ua_addr(ua_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .trap_inst(trap_inst), .trap_data(trap_data), .trap_align(trap_align),
    .grant_all(grant_all)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares registered event outputs against queued expectations
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.req, {28'd0, trap_inst, trap_data, trap_align, grant_all}, {28'd0, e.ev});
    end
  end

  task automatic idle_inputs();
    flt_valid = 0; flt_ifetch = 0; flt_level = 0; flt_kind = 0; flt_acc_idx = 0;
    flt_vaddr = 0; ua_valid = 0; ua_addr = 0; reg_rd = 0; reg_wr = 0;
    reg_sel = 0; reg_wdata = 0;
  endtask

  // model of the status/address update and trap decision, from the requirements
  task automatic tick(input string req);
    logic [3:0]    ev;
    logic [9:0]    base;
    logic          quiet;
    quiet = nofault_mode | ~traps_on;
    ev = {flt_valid & ~quiet & flt_ifetch, flt_valid & ~quiet & ~flt_ifetch,
          ua_valid, flt_valid & quiet};
    q.push_back('{ev, req});
    base = (reg_rd && !reg_sel) ? 10'd0 : m_stat;
    if (flt_valid)
      m_stat = ((base != 0) ? 10'd1 : 10'd0) | {flt_level, flt_acc_idx, flt_kind, 2'b10};
    else if (reg_wr && !reg_sel) m_stat = reg_wdata[9:0];
    else m_stat = base;
    if (flt_valid) m_addr = {flt_vaddr[AW-1:12], 12'd0};
    else if (ua_valid) m_addr = ua_addr;
    else if (reg_wr && reg_sel) m_addr = reg_wdata;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic read_chk(input logic sel, input string req);
    reg_rd = 1; reg_sel = sel;
    #1;
    check(req, reg_rdata, sel ? m_addr : {22'd0, m_stat});
    tick(req);
  endtask

  task automatic fault(input logic ifx, input logic [1:0] lv, input logic [2:0] ac,
                       input logic [2:0] kd, input logic [AW-1:0] va);
    flt_valid = 1; flt_ifetch = ifx; flt_level = lv; flt_acc_idx = ac;
    flt_kind = kd; flt_vaddr = va;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    nofault_mode = 0; traps_on = 1;
    m_stat = 0; m_addr = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 events", {28'd0, trap_inst, trap_data, trap_align, grant_all}, 0);
    read_chk(1'b1, "R1 addr");
    read_chk(1'b0, "R1 stat");

    // R2 R4 R6 data fault
    fault(0, 2'd2, 3'd5, 3'd1, 32'h1234_5678);
    tick("R6 data trap");
    check("R2 fields", {22'd0, m_stat}, 32'h0000_02A6);
    read_chk(1'b1, "R4 page addr");
    read_chk(1'b0, "R2 status");
    read_chk(1'b0, "R8 cleared");

    // R6 instruction fault, then R3 overwrite on unread status
    fault(1, 2'd1, 3'd2, 3'd4, 32'hCAFE_1FFF);
    tick("R6 inst trap");
    fault(0, 2'd3, 3'd7, 3'd2, 32'h0000_3ABC);
    tick("R6 data trap 2");
    read_chk(1'b0, "R3 overwrite");
    read_chk(1'b1, "R4 addr 2");

    // R5 suppression by no-fault mode and by traps disabled
    nofault_mode = 1;
    fault(1, 2'd0, 3'd1, 3'd1, 32'h8000_0123);
    tick("R5 nofault grant");
    nofault_mode = 0; traps_on = 0;
    fault(0, 2'd2, 3'd3, 3'd4, 32'h9000_0456);
    tick("R5 traps off grant");
    traps_on = 1;
    read_chk(1'b0, "R3 overwrite 2");

    // R7 misalignment keeps status, records full address
    ua_valid = 1; ua_addr = 32'hDEAD_BEE3;
    tick("R7 align trap");
    read_chk(1'b1, "R7 addr");
    read_chk(1'b0, "R7 status kept");

    // R7 fault and misalignment together: fault address wins
    fault(0, 2'd1, 3'd0, 3'd1, 32'h4444_5555);
    ua_valid = 1; ua_addr = 32'h0000_0007;
    tick("R7 both events");
    read_chk(1'b1, "R7 fault addr wins");

    // R9 software writes
    reg_wr = 1; reg_sel = 0; reg_wdata = 32'hFFFF_F155;
    tick("R9 write stat");
    read_chk(1'b0, "R9 stat readback");
    reg_wr = 1; reg_sel = 1; reg_wdata = 32'h0BAD_F00D;
    tick("R9 write addr");
    read_chk(1'b1, "R9 addr readback");
    read_chk(1'b1, "R8 addr read no clear");

    // R9 fault overrides status write
    reg_wr = 1; reg_sel = 0; reg_wdata = 32'h0000_03FF;
    fault(1, 2'd2, 3'd6, 3'd3, 32'h7777_7777);
    tick("R9 fault over write");
    read_chk(1'b0, "R9 fault status");

    // R3 R8 fault in same cycle as status read: old value returned, no marker
    fault(0, 2'd3, 3'd1, 3'd5, 32'h1111_2222);
    tick("R6 setup");
    fault(0, 2'd1, 3'd4, 3'd6, 32'h3333_4444);
    read_chk(1'b0, "R8 read with fault");
    read_chk(1'b0, "R3 no marker");
    tick("idle");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule